// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single-channel direct-memory-access engine. Software programs it through a narrow byte port: a 16-bit source address, a 16-bit destination address (used only for memory-to-memory copies), a 16-bit word count, a mode byte, a command byte, a mask bit and a software request bit. Each 16-bit register is loaded one byte at a time. A pointer flip-flop picks the byte: it starts at the low byte and toggles on every access to a 16-bit register. Every 16-bit write loads both the base copy and the working copy of that register.

When the channel is unmasked and enabled and a request is present (device line or software bit), the block raises a bus-hold request and waits for the grant. It then runs transfer cycles and drives address, strobes, device acknowledge and an active-low end-of-process output. A run ends on terminal count or on an external active-low end-of-process input. The pacing mode sets whether the block gives the bus back after every byte (single), keeps it to the end (block), or keeps it while the request stays active (demand). At the end of a run the working registers either reload from the base copies or the channel masks itself.

Top module: `dma_chan_seq`

## Requirements
- R1: Reset and a write to address 7 (master clear) do the following: clear the command register, the software request, the temporary register, the terminal-count flag and the byte pointer, and set the mask bit. After this, status (read address 8) and temporary (read address 9) read 0x00, and the next 16-bit access hits the low byte.
- R2: Addresses 0 (source address), 1 (word count) and 2 (destination address) are accessed low byte first, then high byte. Every read or write of any of them toggles the byte pointer, and a write to address 8 resets it to the low byte. Writes load both the base and the working copy. Reads return the working copy.
- R3: A request is active when (dreq_i or the software request) is set, mask is 0 and command bit 0 (disable) is 0. An active request raises hold_req_o. No transfer cycle occurs until hold_ack_i has been sampled high. The first transfer cycle follows the clock edge at which hold_ack_i is seen.
- R4: Mode byte: bits[1:0] select the kind (00 verify, 01 device-to-memory, 10 memory-to-device, 11 memory-to-memory); bits[3:2] select the pacing (00 demand, 01 single, 10 block); bit4 enables auto-reload; bit5 selects decrement. A device-to-memory cycle asserts dack_o, mem_wr_o and io_rd_o. A memory-to-device cycle asserts dack_o, mem_rd_o and io_wr_o. mem_addr_o carries the working source address.
- R5: A verify cycle asserts dack_o only, with no read or write strobe, yet address and count still step.
- R6: After each transfer the working address moves by one (up, or down when bit5 is set) and the count drops by one. A count of N moves N+1 bytes. eop_no is low during the final transfer cycle, when the count is zero.
- R7: In single pacing exactly one byte moves per bus grant, and hold_req_o drops after every byte.
- R8: In block pacing the bus is kept until terminal count or external end-of-process. A withdrawn dreq_i after the first transfer has no effect.
- R9: In demand pacing the run pauses after the transfer in whose cycle the request is seen inactive. Address and count keep their progress.
- R10: eop_ni low during a transfer cycle ends the run after that cycle without setting the terminal-count flag.
- R11: At the end of a run (terminal count or external end), the working registers reload from the base copies when auto-reload is on. When auto-reload is off, the mask bit sets and further requests are ignored.
- R12: Status (read address 8) holds bit0 = terminal-count flag and bit1 = request pending (dreq_i or software request, regardless of mask). Reading status clears bit0.
- R13: A memory-to-memory byte is a read cycle at the source address, with the data latched into the temporary register, followed by a write cycle at the destination address that drives mem_wdata_o from it. dack_o stays low. The temporary register reads back at address 9.
- R14: A write to address 5 sets or clears the software request from bit0. The software request also clears at the end of any run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_re_i | input | 1 | Register read strobe (advances byte pointer, clears terminal-count flag) |
| cpu_addr_i | input | 4 | Register address |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data |
| dreq_i | input | 1 | Device request |
| hold_req_o | output | 1 | Bus-hold request |
| hold_ack_i | input | 1 | Bus-hold grant |
| dack_o | output | 1 | Device acknowledge, high during device and verify cycles |
| eop_ni | input | 1 | External end-of-process, active low |
| eop_no | output | 1 | Terminal-count end-of-process, active low |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Device read strobe |
| io_wr_o | output | 1 | Device write strobe |
| mem_rdata_i | input | 8 | Memory read data (memory-to-memory) |
| mem_wdata_o | output | 8 | Memory write data (memory-to-memory) |

## Verification
Each transfer kind is tried, and every bus cycle is compared against an expected address, strobe set, end-of-process level and copy data:

- **Single pacing, device-to-memory, with a steady request:** the bus must be released after every byte.
- **Block pacing, verify, with a request that drops after the first byte:** shows that block pacing ignores the withdrawal and that the strobes stay quiet. Decrement and reload are checked twice in a row in this run.
- **Demand pacing, memory-to-device:** the request is cut mid-run to show the pause. The run is then resumed and ended by the external end input, which tells the external end apart from terminal count.
- **Software-requested memory-to-memory copy with known memory data:** shows the read-then-write staging.
- **Master clear issued with a half-written register, a disabled command and a pending software request:** shows what that command restores.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XK_VERIFY = 2'b00, XK_TO_MEM = 2'b01, XK_FROM_MEM = 2'b10, XK_MEM2MEM = 2'b11
  } xkind_e;

  typedef enum logic [1:0] {
    PC_DEMAND = 2'b00, PC_SINGLE = 2'b01, PC_BLOCK = 2'b10, PC_RSVD = 2'b11
  } pace_e;

  typedef struct packed {
    logic   dec;
    logic   reload;
    pace_e  pace;
    xkind_e kind;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_XFER, ST_MRD, ST_MWR
  } seq_e;

  localparam logic [3:0] RA_SRC  = 4'd0;
  localparam logic [3:0] RA_CNT  = 4'd1;
  localparam logic [3:0] RA_DST  = 4'd2;
  localparam logic [3:0] RA_MODE = 4'd3;
  localparam logic [3:0] RA_CMD  = 4'd4;
  localparam logic [3:0] RA_SREQ = 4'd5;
  localparam logic [3:0] RA_MASK = 4'd6;
  localparam logic [3:0] RA_MCLR = 4'd7;
  localparam logic [3:0] RA_STAT = 4'd8;  // read: status, write: pointer clear
  localparam logic [3:0] RA_TEMP = 4'd9;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          dreq_i,
  input  logic          step_i,
  input  logic          end_i,
  input  logic          tc_i,
  input  logic          temp_ld_i,
  input  logic [DW-1:0] temp_d_i,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o,
  output logic [AW-1:0] cur_cnt_o,
  output mode_t         mode_o,
  output logic          req_o,
  output logic [DW-1:0] temp_o
);
  localparam int NB = AW / DW;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  logic [AW-1:0] base_src_q, base_dst_q, base_cnt_q;
  logic [AW-1:0] cur_src_q, cur_dst_q, cur_cnt_q;
  logic [PW-1:0] ptr_q;
  mode_t         mode_q;
  logic          dis_q, mask_q, sreq_q, tc_q;
  logic [DW-1:0] temp_q;

  logic mclr, ptr_clr, wide_hit, stat_rd;
  assign mclr     = we_i && addr_i == RA_MCLR;
  assign ptr_clr  = we_i && addr_i == RA_STAT;
  assign stat_rd  = re_i && addr_i == RA_STAT;
  assign wide_hit = (we_i || re_i) &&
                    (addr_i == RA_SRC || addr_i == RA_CNT || addr_i == RA_DST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (mclr || ptr_clr) begin
      ptr_q <= '0;
    end else if (wide_hit) begin
      ptr_q <= (int'(ptr_q) == NB - 1) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dis_q  <= 1'b0;
      mask_q <= 1'b1;
      sreq_q <= 1'b0;
      tc_q   <= 1'b0;
      temp_q <= '0;
    end else if (mclr) begin
      dis_q  <= 1'b0;
      mask_q <= 1'b1;
      sreq_q <= 1'b0;
      tc_q   <= 1'b0;
      temp_q <= '0;
    end else begin
      if (we_i && addr_i == RA_MODE) mode_q <= mode_t'(wdata_i[5:0]);
      if (we_i && addr_i == RA_CMD)  dis_q  <= wdata_i[0];
      if (we_i && addr_i == RA_MASK) mask_q <= wdata_i[0];
      if (we_i && addr_i == RA_SREQ) sreq_q <= wdata_i[0];
      if (temp_ld_i) temp_q <= temp_d_i;
      if (stat_rd) tc_q <= 1'b0;
      if (tc_i) tc_q <= 1'b1;
      if (end_i) begin
        sreq_q <= 1'b0;
        if (!mode_q.reload) mask_q <= 1'b1;
      end
    end
  end

  // base/working copies survive master clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_src_q <= '0; base_dst_q <= '0; base_cnt_q <= '0;
      cur_src_q  <= '0; cur_dst_q  <= '0; cur_cnt_q  <= '0;
    end else if (step_i) begin
      if (end_i && mode_q.reload) begin
        cur_src_q <= base_src_q;
        cur_dst_q <= base_dst_q;
        cur_cnt_q <= base_cnt_q;
      end else begin
        cur_src_q <= mode_q.dec ? cur_src_q - 1'b1 : cur_src_q + 1'b1;
        cur_dst_q <= mode_q.dec ? cur_dst_q - 1'b1 : cur_dst_q + 1'b1;
        cur_cnt_q <= cur_cnt_q - 1'b1;
      end
    end else if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (int'(ptr_q) == b) begin
          case (addr_i)
            RA_SRC: begin
              base_src_q[b*DW +: DW] <= wdata_i;
              cur_src_q[b*DW +: DW]  <= wdata_i;
            end
            RA_CNT: begin
              base_cnt_q[b*DW +: DW] <= wdata_i;
              cur_cnt_q[b*DW +: DW]  <= wdata_i;
            end
            RA_DST: begin
              base_dst_q[b*DW +: DW] <= wdata_i;
              cur_dst_q[b*DW +: DW]  <= wdata_i;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (addr_i)
      RA_SRC:  rdata_o = DW'(cur_src_q >> (DW * int'(ptr_q)));
      RA_CNT:  rdata_o = DW'(cur_cnt_q >> (DW * int'(ptr_q)));
      RA_DST:  rdata_o = DW'(cur_dst_q >> (DW * int'(ptr_q)));
      RA_STAT: rdata_o = DW'({dreq_i | sreq_q, tc_q});
      RA_TEMP: rdata_o = temp_q;
      default: rdata_o = '0;
    endcase
  end

  assign req_o     = (dreq_i | sreq_q) & ~mask_q & ~dis_q;
  assign cur_src_o = cur_src_q;
  assign cur_dst_o = cur_dst_q;
  assign cur_cnt_o = cur_cnt_q;
  assign mode_o    = mode_q;
  assign temp_o    = temp_q;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          hold_ack_i,
  input  logic          eop_ni,
  input  xkind_e        kind_i,
  input  pace_e         pace_i,
  input  logic [AW-1:0] cur_src_i,
  input  logic [AW-1:0] cur_dst_i,
  input  logic [AW-1:0] cur_cnt_i,
  input  logic [DW-1:0] temp_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          hold_req_o,
  output logic          dack_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          eop_no,
  output logic          step_o,
  output logic          end_o,
  output logic          tc_o,
  output logic          temp_ld_o,
  output logic [DW-1:0] temp_d_o
);
  seq_e st_q, st_d;
  logic last_cyc, tc_now, ext_end;
  logic is_m2m, first_st;

  assign is_m2m   = kind_i == XK_MEM2MEM;
  assign first_st = is_m2m;
  assign last_cyc = st_q == ST_XFER || st_q == ST_MWR;
  assign tc_now   = last_cyc && cur_cnt_i == '0;
  assign ext_end  = last_cyc && !eop_ni;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_i) st_d = ST_HOLD;
      ST_HOLD: if (hold_ack_i) st_d = first_st ? ST_MRD : ST_XFER;
      ST_MRD:  st_d = ST_MWR;
      ST_XFER, ST_MWR: begin
        if (tc_now || ext_end) st_d = ST_IDLE;
        else begin
          case (pace_i)
            PC_BLOCK:  st_d = is_m2m ? ST_MRD : ST_XFER;
            PC_DEMAND: st_d = req_i ? (is_m2m ? ST_MRD : ST_XFER) : ST_IDLE;
            default:   st_d = ST_IDLE;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign hold_req_o  = st_q != ST_IDLE;
  assign dack_o      = st_q == ST_XFER;
  assign mem_addr_o  = (st_q == ST_MWR) ? cur_dst_i : cur_src_i;
  assign mem_rd_o    = (dack_o && kind_i == XK_FROM_MEM) || st_q == ST_MRD;
  assign mem_wr_o    = (dack_o && kind_i == XK_TO_MEM) || st_q == ST_MWR;
  assign io_rd_o     = dack_o && kind_i == XK_TO_MEM;
  assign io_wr_o     = dack_o && kind_i == XK_FROM_MEM;
  assign mem_wdata_o = temp_i;
  assign eop_no      = !tc_now;
  assign step_o      = last_cyc;
  assign end_o       = tc_now || ext_end;
  assign tc_o        = tc_now;
  assign temp_ld_o   = st_q == ST_MRD;
  assign temp_d_o    = mem_rdata_i;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_we_i,
  input  logic          cpu_re_i,
  input  logic [3:0]    cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          dreq_i,
  output logic          hold_req_o,
  input  logic          hold_ack_i,
  output logic          dack_o,
  input  logic          eop_ni,
  output logic          eop_no,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o
);
  logic [AW-1:0] cur_src, cur_dst, cur_cnt;
  logic [DW-1:0] temp, temp_d;
  mode_t         mode;
  logic          req, step, run_end, tc, temp_ld;

  dma_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cpu_we_i), .re_i(cpu_re_i), .addr_i(cpu_addr_i),
    .wdata_i(cpu_wdata_i), .rdata_o(cpu_rdata_o),
    .dreq_i, .step_i(step), .end_i(run_end), .tc_i(tc),
    .temp_ld_i(temp_ld), .temp_d_i(temp_d),
    .cur_src_o(cur_src), .cur_dst_o(cur_dst), .cur_cnt_o(cur_cnt),
    .mode_o(mode), .req_o(req), .temp_o(temp)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .req_i(req), .hold_ack_i, .eop_ni,
    .kind_i(mode.kind), .pace_i(mode.pace),
    .cur_src_i(cur_src), .cur_dst_i(cur_dst), .cur_cnt_i(cur_cnt),
    .temp_i(temp), .mem_rdata_i,
    .hold_req_o, .dack_o, .mem_addr_o, .mem_rd_o, .mem_wr_o,
    .io_rd_o, .io_wr_o, .mem_wdata_o, .eop_no,
    .step_o(step), .end_o(run_end), .tc_o(tc),
    .temp_ld_o(temp_ld), .temp_d_o(temp_d)
  );
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk
  import dma_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_ack_i,
  input logic          dack_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          io_rd_o,
  input logic          io_wr_o,
  input mode_t         mode,
  input logic          step,
  input logic          run_end,
  input logic          req,
  input logic [AW-1:0] cur_src
);
  AST_ACK_BEFORE_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> $past(hold_ack_i)); // R3

  AST_VERIFY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode.kind == XK_VERIFY) |-> !(mem_rd_o || mem_wr_o || io_rd_o || io_wr_o)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !run_end && !mode.dec) |=> cur_src == $past(cur_src) + 1'b1); // R6

  AST_SINGLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode.pace == PC_SINGLE) |=> !dack_o); // R7

  AST_BLOCK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode.pace == PC_BLOCK && !run_end) |=> dack_o); // R8

  AST_MASK_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_end && !mode.reload) |=> !req); // R11

  AST_COPY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !dack_o) |-> $past(mem_rd_o)); // R13
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_ack_i(hold_ack_i),
  .dack_o(dack_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .mode(mode),
  .step(step), .run_end(run_end), .req(req), .cur_src(cur_src)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, re = 0, dreq = 0, eop_n = 1, ack_en = 0, hold_ack = 0;
  logic [3:0] a = '0;
  logic [7:0] wd = '0, rdata, mem_rdata, mem_wdata;
  logic [15:0] mem_addr;
  logic hold_req, dack, eop_o, mem_rd, mem_wr, io_rd, io_wr;

  int n_chk = 0, n_fail = 0, n_xfer = 0, n_rel = 0;
  logic prev_hr = 1'b0;

  typedef struct { logic [31:0] v; bit cw; string tag; } item_t;
  item_t exp_q[$];
  item_t mon_it;
  logic [31:0] mon_act;

  always #4 clk = ~clk;

  dma_chan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_re_i(re),
    .cpu_addr_i(a), .cpu_wdata_i(wd), .cpu_rdata_o(rdata),
    .dreq_i(dreq), .hold_req_o(hold_req), .hold_ack_i(hold_ack),
    .dack_o(dack), .eop_ni(eop_n), .eop_no(eop_o),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr),
    .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata)
  );

  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;
  always @(posedge clk) hold_ack <= ack_en && hold_req;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (dack || mem_rd || mem_wr)) begin
      n_xfer++;
      mon_act = {mem_addr, mem_rd, mem_wr, io_rd, io_wr, eop_o, dack, 2'b00, mem_wdata};
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4 unexpected cycle act=%h exp=none", mon_act);
      end else begin
        mon_it = exp_q.pop_front();
        if (!mon_it.cw) mon_act[7:0] = 8'h00;
        check(mon_it.tag, mon_act, mon_it.v);
      end
    end
    if (prev_hr && !hold_req) n_rel++;
    prev_hr = hold_req;
  end

  task automatic push(input logic [15:0] ad, input logic mr, mw, ir, iw, eo, dk,
                      input logic [7:0] d, input bit cw, input string tag);
    item_t it;
    it.v = {ad, mr, mw, ir, iw, eo, dk, 2'b00, cw ? d : 8'h00};
    it.cw = cw; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [3:0] ad, input logic [7:0] d);
    @(posedge clk); #1; we = 1; a = ad; wd = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [3:0] ad, output logic [7:0] d);
    @(posedge clk); #1; re = 1; a = ad;
    @(negedge clk); d = rdata;
    @(posedge clk); #1; re = 0;
  endtask

  task automatic wr16(input logic [3:0] ad, input logic [15:0] v);
    wr(ad, v[7:0]); wr(ad, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] ad, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'd8, 8'h00);
    rd(ad, lo); rd(ad, hi);
    v = {hi, lo};
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (!hold_req && exp_q.size() == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_xfers(input int target);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (n_xfer >= target) break;
    end
  endtask

  function automatic logic [7:0] mk_mode(input logic dec, rl, input logic [1:0] pace, kind);
    return {2'b00, dec, rl, pace, kind};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);

    // reset state
    check("R1 reset hold_req", {31'd0, hold_req}, 32'd0);
    check("R1 reset eop_no", {31'd0, eop_o}, 32'd1);
    rd(4'd8, b); check("R1 reset status", {24'd0, b}, 32'h00);
    rd(4'd9, b); check("R1 reset temp", {24'd0, b}, 32'h00);

    // single pacing, device-to-memory
    wr(4'd8, 8'h00);
    wr16(4'd0, 16'h1234);
    wr16(4'd1, 16'h0002);
    wr(4'd3, mk_mode(0, 0, 2'b01, 2'b01));
    rd16(4'd0, w); check("R2 byte-wise readback", {16'd0, w}, 32'h1234);
    wr(4'd6, 8'h00);
    dreq = 1;
    repeat (6) @(negedge clk);
    check("R3 hold raised without grant", {31'd0, hold_req}, 32'd1);
    check("R3 no cycle before grant", n_xfer, 0);
    push(16'h1234, 0, 1, 1, 0, 1, 1, 8'h00, 0, "R4 R7 to-mem byte0");
    push(16'h1235, 0, 1, 1, 0, 1, 1, 8'h00, 0, "R4 R7 to-mem byte1");
    push(16'h1236, 0, 1, 1, 0, 0, 1, 8'h00, 0, "R6 to-mem last byte eop");
    n_rel = 0;
    ack_en = 1;
    wait_done();
    dreq = 0;
    check("R7 bus released per byte", n_rel, 3);
    rd(4'd8, b); check("R12 status tc set", {24'd0, b}, 32'h01);
    rd(4'd8, b); check("R12 status tc cleared by read", {24'd0, b}, 32'h00);
    rd16(4'd0, w); check("R6 address stepped up", {16'd0, w}, 32'h1237);
    rd16(4'd1, w); check("R6 count wrapped", {16'd0, w}, 32'hFFFF);
    dreq = 1;
    repeat (6) @(negedge clk);
    check("R11 masked after end", {31'd0, hold_req}, 32'd0);
    dreq = 0;

    // block pacing, verify, decrement, reload
    wr16(4'd0, 16'h0010);
    wr16(4'd1, 16'h0003);
    wr(4'd3, mk_mode(1, 1, 2'b10, 2'b00));
    wr(4'd6, 8'h00);
    for (int k = 0; k < 2; k++) begin
      push(16'h0010, 0, 0, 0, 0, 1, 1, 8'h00, 0, "R5 verify quiet 0");
      push(16'h000F, 0, 0, 0, 0, 1, 1, 8'h00, 0, "R8 R6 verify dec 1");
      push(16'h000E, 0, 0, 0, 0, 1, 1, 8'h00, 0, "R8 verify dec 2");
      push(16'h000D, 0, 0, 0, 0, 0, 1, 8'h00, 0, "R8 verify last eop");
      base = n_xfer;
      dreq = 1;
      wait_xfers(base + 1);
      dreq = 0;
      wait_done();
      check("R8 block ran to terminal count", n_xfer - base, 4);
      rd16(4'd0, w); check("R11 address reloaded", {16'd0, w}, 32'h0010);
      rd16(4'd1, w); check("R11 count reloaded", {16'd0, w}, 32'h0003);
    end
    wr(4'd6, 8'h01);
    rd(4'd8, b);

    // demand pacing, memory-to-device
    wr16(4'd0, 16'h0200);
    wr16(4'd1, 16'h0009);
    wr(4'd3, mk_mode(0, 0, 2'b00, 2'b10));
    wr(4'd6, 8'h00);
    push(16'h0200, 1, 0, 0, 1, 1, 1, 8'h00, 0, "R4 from-mem 0");
    push(16'h0201, 1, 0, 0, 1, 1, 1, 8'h00, 0, "R4 from-mem 1");
    push(16'h0202, 1, 0, 0, 1, 1, 1, 8'h00, 0, "R9 from-mem 2");
    base = n_xfer;
    dreq = 1;
    wait_xfers(base + 3);
    dreq = 0;
    wait_done();
    check("R9 demand paused after request drop", n_xfer - base, 3);
    rd16(4'd1, w); check("R9 count kept", {16'd0, w}, 32'h0006);
    push(16'h0203, 1, 0, 0, 1, 1, 1, 8'h00, 0, "R10 resumed byte");
    base = n_xfer;
    dreq = 1;
    wait_xfers(base + 1);
    eop_n = 0;
    wait_done();
    eop_n = 1;
    dreq = 0;
    check("R10 external end stopped run", n_xfer - base, 1);
    rd16(4'd1, w); check("R10 count after external end", {16'd0, w}, 32'h0005);
    rd(4'd8, b); check("R10 no tc flag on external end", {24'd0, b}, 32'h00);
    dreq = 1;
    repeat (6) @(negedge clk);
    check("R11 masked after external end", {31'd0, hold_req}, 32'd0);
    dreq = 0;

    // memory-to-memory, software request
    wr16(4'd0, 16'h0040);
    wr16(4'd1, 16'h0001);
    wr16(4'd2, 16'h0080);
    wr(4'd3, mk_mode(0, 0, 2'b10, 2'b11));
    wr(4'd5, 8'h01);
    rd(4'd8, b); check("R14 soft request pending", {24'd0, b}, 32'h02);
    wr(4'd5, 8'h00);
    rd(4'd8, b); check("R14 soft request cleared by write", {24'd0, b}, 32'h00);
    push(16'h0040, 1, 0, 0, 0, 1, 0, 8'h00, 0, "R13 copy read 0");
    push(16'h0080, 0, 1, 0, 0, 1, 0, 8'hE5, 1, "R13 copy write 0");
    push(16'h0041, 1, 0, 0, 0, 1, 0, 8'h00, 0, "R13 copy read 1");
    push(16'h0081, 0, 1, 0, 0, 0, 0, 8'hE4, 1, "R13 copy write 1");
    wr(4'd6, 8'h00);
    wr(4'd5, 8'h01);
    wait_done();
    rd(4'd8, b); check("R14 soft request cleared at end", {24'd0, b}, 32'h01);
    rd(4'd9, b); check("R13 temp holds last byte", {24'd0, b}, 32'hE4);

    // master clear
    wr(4'd8, 8'h00);
    wr(4'd0, 8'hAA);
    wr(4'd4, 8'h01);
    wr(4'd5, 8'h01);
    wr(4'd7, 8'h00);
    rd(4'd8, b); check("R1 status after master clear", {24'd0, b}, 32'h00);
    rd(4'd9, b); check("R1 temp after master clear", {24'd0, b}, 32'h00);
    wr(4'd0, 8'h77);
    wr(4'd0, 8'h66);
    wr(4'd8, 8'h00);
    rd(4'd0, b); rd(4'd0, w[15:8]); w[7:0] = b;
    check("R1 R2 pointer cleared by master clear", {16'd0, w}, 32'h6677);
    wr16(4'd1, 16'h0000);
    wr(4'd3, mk_mode(0, 0, 2'b01, 2'b00));
    push(16'h6677, 0, 0, 0, 0, 0, 1, 8'h00, 0, "R1 command enabled after clear");
    base = n_xfer;
    wr(4'd6, 8'h00);
    dreq = 1;
    wait_done();
    dreq = 0;
    check("R1 one verify byte ran", n_xfer - base, 1);
    check("R4 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end
endmodule